// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is a register-driven SPI master. Software fills a byte-wide transmit queue, writes how many bytes the burst lasts and how many of them come from the queue, and then sets a start bit. The engine shifts the burst out one byte after another, most significant bit first, and captures one received byte into a receive queue for every byte it sends. While the burst runs, the start bit reads back as one. It clears itself once the last byte has been shifted and captured. Software polls the receive fill level and drains the queue through a read port that pops one byte per read.

Serial timing comes from an external enable, `sck_tick`. Each cycle with the enable high advances the serial clock by one half period. All four clock polarity and phase combinations are supported. Four chip-select lines are provided. The selected line can either follow the burst automatically, with a programmable active level, or be held at a level that software writes. Each queue has its own flush bit.

Register offsets on `reg_addr`: control 0x00, transmit data 0x04 (write), receive data 0x08 (read, pops), burst length 0x0C, queued-byte count 0x10, status 0x14 (receive fill level in bits 6:0). Reads return data one cycle after `reg_rd`.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, control and status read 0x0, `cs_o` is 4'b0000, and `sclk` and `mosi` are 0.
- R2: Bytes leave MSB first on `mosi`. The bits sampled at each sampling edge of `sclk` rebuild the queued bytes in order. The captured `miso` bytes come back in the same order from the receive data register.
- R3: Control bit 10 starts a burst and reads 1 while the burst runs. It reads 0 again once the last byte is captured.
- R4: Status bits 6:0 give the number of bytes in the receive queue. Each read of the receive data register removes one byte.
- R5: The first N bytes of a burst, where N is the queued-byte count, are taken from the transmit queue. Every later byte, and any byte for which the queue is empty, is sent as 0x00.
- R6: Control bit 3 (CPOL) sets the idle level of `sclk`. Control bit 2 (CPHA) set to 0 samples on the leading edge and shifts on the trailing edge; set to 1 it does the reverse. Each byte takes exactly 16 `sclk` transitions.
- R7: With control bit 16 clear, the line chosen by control bits 13:12 is at its active level only while a burst runs. The active level is 0 when control bit 4 is set and 1 otherwise. Every other line sits at the inactive level.
- R8: With control bit 16 set, the selected line is driven to the value of control bit 17, whether or not a burst is running. The other lines stay inactive.
- R9: Writing control with bit 8 set empties the transmit queue, and with bit 9 set empties the receive queue. Both bits read back as 0.
- R10: A start request is ignored, so that no `sclk` edge occurs and bit 10 reads 0, when control bit 0 (enable) or bit 1 (master) is clear in the same write, or when the burst length is 0.
- R11: The queues hold 64 bytes each. Received bytes that arrive while the receive queue is full are dropped, and the fill level stops at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| sck_tick | input | 1 | Serial clock half-period enable |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | 4 | Chip-select lines |

## Verification
The bench watches `sclk` and `mosi` directly and rebuilds each byte at the sampling edge implied by its own mode setting. A shifter that samples on the wrong edge or sends LSB first therefore shows up as a wrong byte, and a stray half-period shows up as a transition count other than 16 per byte. It runs a burst longer than the queued-byte count, to catch an engine that keeps popping stale queue entries instead of sending zeros. It also runs a burst longer than the queue depth, to catch a receive count that wraps. Start requests with enable or master clear, or with a zero length, must produce no clock at all. Chip select is checked throughout each burst and after it, in both automatic and manual modes, so a wrong polarity or a line that leaks into a neighbour fails.

// File: rtl/spi_burst_pkg.sv
// Package: shared register offsets, control bit positions and engine states
// for the SPI burst master. Assumes byte offsets on an 8-bit address.
package spi_burst_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_BLEN  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_QCNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;

    localparam int B_EN      = 0;
    localparam int B_MASTER  = 1;
    localparam int B_CPHA    = 2;
    localparam int B_CPOL    = 3;
    localparam int B_ACTLOW  = 4;
    localparam int B_TXFLUSH = 8;
    localparam int B_RXFLUSH = 9;
    localparam int B_GO      = 10;
    localparam int B_SEL_LSB = 12;
    localparam int B_MANUAL  = 16;
    localparam int B_LEVEL   = 17;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_WAIT = 2'd2
    } burst_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
// Synchronous FIFO with fill count. Assumes one clock domain; a push when
// full and a pop when empty are ignored; flush clears it in one cycle and
// wins over a push or pop in the same cycle.
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and count bookkeeping with flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R11: the fill level never exceeds the depth.
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R9: a flush leaves the queue empty on the next cycle.
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/spi_byte_shifter.sv
// One-byte SPI shift engine for all four clock modes. Assumes cpol and cpha
// stay constant while busy. Every tick while busy is one sclk half period;
// a byte takes 2*W ticks. done pulses for one cycle once rx_byte holds the
// full captured byte.
module spi_byte_shifter #(
    parameter int W   = 8,
    localparam int EW = $clog2(2 * W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

    logic          sclk_q;
    logic [W-1:0]  sh;
    logic [EW-1:0] ecnt;

    assign sclk = busy ? sclk_q : cpol;

    // Edge sequencing: shift out and sample on the edges the mode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk_q  <= 1'b0;
            mosi    <= 1'b0;
            sh      <= '0;
            rx_byte <= '0;
            ecnt    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                ecnt   <= '0;
                sclk_q <= cpol;
                if (!cpha) begin
                    mosi <= tx_byte[W-1];
                    sh   <= {tx_byte[W-2:0], 1'b0};
                end else begin
                    sh   <= tx_byte;
                end
            end else if (busy && tick) begin
                sclk_q <= ~sclk_q;
                ecnt   <= ecnt + 1'b1;
                if (!ecnt[0]) begin
                    if (cpha) begin
                        mosi <= sh[W-1];
                        sh   <= {sh[W-2:0], 1'b0};
                    end else begin
                        rx_byte <= {rx_byte[W-2:0], miso};
                    end
                end else begin
                    if (cpha) begin
                        rx_byte <= {rx_byte[W-2:0], miso};
                    end else if (ecnt != LAST_EDGE) begin
                        mosi <= sh[W-1];
                        sh   <= {sh[W-2:0], 1'b0};
                    end
                end
                if (ecnt == LAST_EDGE) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R6: every tick during a byte moves sclk by one transition.
    a_r6_sclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && !start) |=> (sclk != $past(sclk)));
endmodule

// File: rtl/spi_burst_master.sv
// SPI master burst engine: register decode, burst sequencer and chip-select
// drive around two byte queues and a byte shifter. Assumes software starts a
// burst only when idle and does not change the mode bits during a burst.
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 24,
    parameter int NCS        = 4,
    localparam int SEL_W     = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sck_tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NCS-1:0]    cs_o
);
    // Stored control fields.
    logic             en_q, master_q, cpha_q, cpol_q, actlow_q, manual_q, level_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] blen_q, qcnt_q, idx_q;
    logic             running_q;
    burst_state_e     st_q;

    // Queue and shifter wiring.
    logic             tx_push, tx_pop, tx_flush, tx_full, tx_empty;
    logic [7:0]       tx_dout;
    logic [FCW-1:0]   tx_count_unused;
    logic             rx_push, rx_pop, rx_flush, rx_full_unused, rx_empty;
    logic [7:0]       rx_dout;
    logic [FCW-1:0]   rx_count;
    logic             sh_start, sh_busy, sh_done, use_tx;
    logic [7:0]       sh_tx, sh_rx;
    logic             wr_ctrl, go_req, unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

    assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    assign tx_flush = wr_ctrl && reg_wdata[B_TXFLUSH];
    assign rx_flush = wr_ctrl && reg_wdata[B_RXFLUSH];
    assign go_req   = wr_ctrl && reg_wdata[B_GO] && reg_wdata[B_EN]
                      && reg_wdata[B_MASTER] && (blen_q != '0) && !running_q;
    assign tx_push  = reg_wr && (reg_addr == OFS_TXD);
    assign rx_pop   = reg_rd && (reg_addr == OFS_RXD) && !rx_empty;

    assign sh_start = (st_q == ST_LOAD);
    assign use_tx   = (idx_q < qcnt_q) && !tx_empty;
    assign tx_pop   = sh_start && use_tx;
    assign sh_tx    = use_tx ? tx_dout : 8'h00;
    assign rx_push  = (st_q == ST_WAIT) && sh_done;

    spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
        .din(reg_wdata[7:0]), .pop(tx_pop), .dout(tx_dout),
        .count(tx_count_unused), .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
        .din(sh_rx), .pop(rx_pop), .dout(rx_dout),
        .count(rx_count), .full(rx_full_unused), .empty(rx_empty)
    );

    spi_byte_shifter #(.W(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .cpol(cpol_q), .cpha(cpha_q),
        .tick(sck_tick), .start(sh_start), .tx_byte(sh_tx), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(sh_busy), .done(sh_done),
        .rx_byte(sh_rx)
    );

    // Register writes and the burst sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            master_q  <= 1'b0;
            cpha_q    <= 1'b0;
            cpol_q    <= 1'b0;
            actlow_q  <= 1'b0;
            manual_q  <= 1'b0;
            level_q   <= 1'b0;
            sel_q     <= '0;
            blen_q    <= '0;
            qcnt_q    <= '0;
            idx_q     <= '0;
            running_q <= 1'b0;
            st_q      <= ST_IDLE;
        end else begin
            if (wr_ctrl) begin
                en_q     <= reg_wdata[B_EN];
                master_q <= reg_wdata[B_MASTER];
                cpha_q   <= reg_wdata[B_CPHA];
                cpol_q   <= reg_wdata[B_CPOL];
                actlow_q <= reg_wdata[B_ACTLOW];
                manual_q <= reg_wdata[B_MANUAL];
                level_q  <= reg_wdata[B_LEVEL];
                sel_q    <= reg_wdata[B_SEL_LSB +: SEL_W];
            end
            if (reg_wr && reg_addr == OFS_BLEN) blen_q <= reg_wdata[CNT_W-1:0];
            if (reg_wr && reg_addr == OFS_QCNT) qcnt_q <= reg_wdata[CNT_W-1:0];
            if (go_req) begin
                running_q <= 1'b1;
                idx_q     <= '0;
                st_q      <= ST_LOAD;
            end
            case (st_q)
                ST_LOAD: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q + 1'b1 == blen_q) begin
                            running_q <= 1'b0;
                            st_q      <= ST_IDLE;
                        end else begin
                            st_q <= ST_LOAD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Registered read data; the receive port pops on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= '0;
            case (reg_addr)
                OFS_CTRL: begin
                    reg_rdata[B_EN]                 <= en_q;
                    reg_rdata[B_MASTER]             <= master_q;
                    reg_rdata[B_CPHA]               <= cpha_q;
                    reg_rdata[B_CPOL]               <= cpol_q;
                    reg_rdata[B_ACTLOW]             <= actlow_q;
                    reg_rdata[B_GO]                 <= running_q;
                    reg_rdata[B_SEL_LSB +: SEL_W]   <= sel_q;
                    reg_rdata[B_MANUAL]             <= manual_q;
                    reg_rdata[B_LEVEL]              <= level_q;
                end
                OFS_RXD:  reg_rdata[7:0]   <= rx_empty ? 8'h00 : rx_dout;
                OFS_BLEN: reg_rdata[CNT_W-1:0] <= blen_q;
                OFS_QCNT: reg_rdata[CNT_W-1:0] <= qcnt_q;
                OFS_STAT: reg_rdata[FCW-1:0]   <= rx_count;
                default:  ;
            endcase
        end
    end

    // Chip-select drive, one line per generate slot.
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        always_comb begin
            if (sel_q == SEL_W'(i))
                cs_o[i] = manual_q ? level_q : (running_q ? ~actlow_q : actlow_q);
            else
                cs_o[i] = actlow_q;
        end
    end

    // R3: the shifter only runs while a burst is in progress.
    a_r3_shift_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> running_q);

    // R10: a byte only starts from a burst that was accepted.
    a_r10_start_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> $past(running_q));

    // R7: in automatic mode at most one line leaves the inactive level.
    a_r7_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !manual_q |-> ($countones(cs_o ^ {NCS{actlow_q}}) <= 1));

    // R11: the transmit queue is never popped when empty.
    a_r11_tx_pop_ok: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    logic unused_flags;
    assign unused_flags = ^{tx_full, unused_wdata};
endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00, A_TXD = 8'h04, A_RXD = 8'h08,
                           A_BLEN = 8'h0C, A_QCNT = 8'h10, A_STAT = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck_tick = 1'b0;
    logic        sclk, mosi;
    logic [3:0]  cs_o;
    logic        miso;

    assign miso = mosi;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_tick(sck_tick), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_o(cs_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int tick_div = 1;
    logic b_cpol = 1'b0, b_cpha = 1'b0;
    logic [3:0] exp_cs = '0;
    logic [7:0] tx_q [128];
    logic [7:0] mon_bytes [128];
    int mon_n = 0, mon_bits = 0, mon_edges = 0, cs_err = 0;
    logic [7:0] mon_sh = '0;
    logic prev_sclk = 1'b0;

    // Tick generator.
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            sck_tick = ((tc % tick_div) == 0);
        end
    end

    // Line monitor: rebuilds bytes at the sampling edge of the bench's mode.
    initial begin
        forever begin
            @(negedge clk);
            if (sclk != prev_sclk) begin
                mon_edges++;
                if ((sclk != b_cpol) != b_cpha) begin
                    mon_sh = {mon_sh[6:0], mosi};
                    mon_bits++;
                    if (cs_o != exp_cs) cs_err++;
                    if (mon_bits == 8) begin
                        if (mon_n < 128) mon_bytes[mon_n] = mon_sh;
                        mon_n++;
                        mon_bits = 0;
                    end
                end
            end
            prev_sclk = sclk;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic clear_mon();
        mon_n = 0; mon_bits = 0; mon_edges = 0; cs_err = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 20000; k++) begin
            rd(A_CTRL, d);
            if (!d[10]) break;
        end
    endtask

    function automatic logic [31:0] cfg(input logic cpol, input logic cpha,
                                        input logic al, input logic [1:0] sel);
        return 32'h3 | (32'(cpha) << 2) | (32'(cpol) << 3) | (32'(al) << 4)
               | (32'(sel) << 12);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_STAT, d); check("R1 status", d, 0);
        check("R1 cs", 32'(cs_o), 0);
        check("R1 sclk", 32'(sclk), 0);
        check("R1 mosi", 32'(mosi), 0);
    endtask

    task automatic t_mode(input logic cpol, input logic cpha, input logic al,
                          input logic [1:0] sel, input int n);
        logic [31:0] d, base;
        base = cfg(cpol, cpha, al, sel);
        b_cpol = cpol; b_cpha = cpha;
        wr(A_CTRL, base | 32'h300);
        wr(A_BLEN, 32'(n));
        wr(A_QCNT, 32'(n));
        for (int k = 0; k < n; k++) begin
            tx_q[k] = 8'hA5 ^ 8'(k * 37 + int'(sel) * 16 + int'(cpol) * 3);
            wr(A_TXD, 32'(tx_q[k]));
        end
        exp_cs = {4{al}};
        exp_cs[sel] = ~al;
        clear_mon();
        wr(A_CTRL, base | 32'h400);
        wait_idle();
        check("R6 edge count", 32'(mon_edges), 32'(16 * n));
        check("R6 idle level", 32'(sclk), 32'(cpol));
        check("R2 byte count on line", 32'(mon_n), 32'(n));
        for (int k = 0; k < n; k++) check("R2 line byte", 32'(mon_bytes[k]), 32'(tx_q[k]));
        check("R7 cs during burst", 32'(cs_err), 0);
        check("R7 cs after burst", 32'(cs_o), 32'({4{al}}));
        rd(A_STAT, d); check("R4 rx level", d, 32'(n));
        for (int k = 0; k < n; k++) begin
            rd(A_RXD, d); check("R2 rx byte", d, 32'(tx_q[k]));
        end
        rd(A_STAT, d); check("R4 rx level drained", d, 0);
    endtask

    task automatic t_go_readback();
        logic [31:0] d, base;
        base = cfg(1'b0, 1'b0, 1'b1, 2'd0);
        tick_div = 4;
        b_cpol = 1'b0; b_cpha = 1'b0;
        wr(A_CTRL, base | 32'h300);
        wr(A_BLEN, 2); wr(A_QCNT, 0);
        wr(A_CTRL, base | 32'h400);
        rd(A_CTRL, d); check("R3 go reads one while running", d, base | 32'h400);
        wait_idle();
        rd(A_CTRL, d); check("R3 go self-clears", d, base);
        tick_div = 1;
    endtask

    task automatic t_pad();
        logic [31:0] d, base;
        base = cfg(1'b0, 1'b1, 1'b0, 2'd1);
        b_cpol = 1'b0; b_cpha = 1'b1;
        exp_cs = 4'b0010;
        wr(A_CTRL, base | 32'h300);
        wr(A_BLEN, 4); wr(A_QCNT, 2);
        wr(A_TXD, 32'h3C); wr(A_TXD, 32'hC3); wr(A_TXD, 32'h77); wr(A_TXD, 32'h88);
        clear_mon();
        wr(A_CTRL, base | 32'h400);
        wait_idle();
        check("R5 queued byte 0", 32'(mon_bytes[0]), 32'h3C);
        check("R5 queued byte 1", 32'(mon_bytes[1]), 32'hC3);
        check("R5 pad byte 2", 32'(mon_bytes[2]), 32'h00);
        check("R5 pad byte 3", 32'(mon_bytes[3]), 32'h00);
        wr(A_CTRL, base | 32'h300);
        rd(A_CTRL, d); check("R9 flush bits read zero", d, base);
        rd(A_STAT, d); check("R9 rx flushed", d, 0);
        wr(A_BLEN, 3); wr(A_QCNT, 3);
        clear_mon();
        wr(A_CTRL, base | 32'h400);
        wait_idle();
        check("R9 tx flushed, three bytes sent", 32'(mon_n), 3);
        check("R5 empty queue sends zero", 32'({mon_bytes[0], mon_bytes[1], mon_bytes[2]}), 0);
        rd(A_STAT, d); check("R4 level after pad burst", d, 3);
        wr(A_CTRL, base | 32'h200);
        rd(A_STAT, d); check("R9 rx flush empties", d, 0);
    endtask

    task automatic t_manual();
        logic [31:0] base;
        base = cfg(1'b1, 1'b0, 1'b1, 2'd2) | (32'h1 << 16);
        b_cpol = 1'b1; b_cpha = 1'b0;
        wr(A_CTRL, base | 32'h300);
        check("R8 manual level low", 32'(cs_o), 32'h0B);
        wr(A_BLEN, 1); wr(A_QCNT, 0);
        exp_cs = 4'b1011;
        clear_mon();
        wr(A_CTRL, base | 32'h400);
        wait_idle();
        check("R8 cs held through burst", 32'(cs_err), 0);
        check("R8 burst ran", 32'(mon_n), 1);
        base = cfg(1'b1, 1'b0, 1'b0, 2'd2) | (32'h3 << 16);
        wr(A_CTRL, base | 32'h200);
        check("R8 manual level high", 32'(cs_o), 32'h04);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        b_cpol = 1'b0; b_cpha = 1'b0;
        wr(A_CTRL, 32'h300);
        wr(A_BLEN, 3); wr(A_QCNT, 0);
        clear_mon();
        wr(A_CTRL, 32'h402);
        repeat (100) @(negedge clk);
        rd(A_CTRL, d); check("R10 no start without enable", 32'(d[10]), 0);
        wr(A_CTRL, 32'h401);
        repeat (100) @(negedge clk);
        rd(A_CTRL, d); check("R10 no start without master", 32'(d[10]), 0);
        wr(A_BLEN, 0);
        wr(A_CTRL, 32'h403);
        repeat (100) @(negedge clk);
        rd(A_CTRL, d); check("R10 no start with zero length", 32'(d[10]), 0);
        check("R10 no sclk edges", 32'(mon_edges), 0);
        rd(A_STAT, d); check("R10 rx untouched", d, 0);
    endtask

    task automatic t_full();
        logic [31:0] d, base;
        base = cfg(1'b0, 1'b0, 1'b0, 2'd3);
        b_cpol = 1'b0; b_cpha = 1'b0;
        wr(A_CTRL, base | 32'h300);
        wr(A_BLEN, 70); wr(A_QCNT, 0);
        wr(A_CTRL, base | 32'h400);
        wait_idle();
        rd(A_STAT, d); check("R11 level stops at depth", d, 64);
        rd(A_RXD, d); check("R11 first kept byte", d, 0);
        rd(A_STAT, d); check("R11 level after one read", d, 63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode(1'b0, 1'b0, 1'b0, 2'd0, 4);
        t_mode(1'b0, 1'b1, 1'b1, 2'd1, 4);
        t_mode(1'b1, 1'b0, 1'b0, 2'd2, 3);
        t_mode(1'b1, 1'b1, 1'b1, 2'd3, 5);
        t_go_readback();
        t_pad();
        t_manual();
        t_ignore();
        t_full();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule